// File: doc/BRIEF.md
# Peripheral Interrupt Masking and Vectoring Unit

This unit collects interrupt events from five peripheral sources and offers the processor core one request at a time. The sources are an external interrupt pin, a passive-mode parallel write, a passive-mode parallel read, a serial-port write and a serial-port read. Each source is enabled through two control registers on a simple write/read port. A source enabled only through the shared-vector register is steered to one common vector address. A source enabled through the per-source register gets its own vector address.

While a request is offered, the unit drives the vector address of the highest-priority enabled pending source. When the core accepts, the unit clears that source's pending flag and raises an acknowledge output. The acknowledge output stays high until the core signals the end of the service routine, and no further request is offered in that window. Events that arrive in that window are held pending and are served after the acknowledge output drops.

Top module: `perIrqVectorUnit`

## Requirements
- R1: After reset, irqReq, ackOut and vecAddr are 0, and both registers read back as 0.
- R2: Register address 0 is the shared-vector mask register. Its enable bits are: external pin at bit 5, parallel read at bit 6, parallel write at bit 7, serial read at bit 8, serial write at bit 9. Address 1 is the per-source enable register: external pin at bit 0, parallel write at bit 1, parallel read at bit 2, serial write at bit 3, serial read at bit 4. A write takes effect at the clock edge. All other bits read as 0.
- R3: An event from a source whose bit is 0 in both registers is not recorded and never raises irqReq.
- R4: A rising edge on parInStb is a parallel-write event and a rising edge on parOutStb is a parallel-read event. Both count only while passiveMode is 1. A rising edge on extIntPin is a pin event. Each cycle that serWrEvt or serRdEvt is high is one event.
- R5: An enabled event sampled at a clock edge makes irqReq high from that edge onward, provided ackOut is low.
- R6: When several enabled sources are pending, the one served is chosen in this order: external pin, parallel write, parallel read, serial write, serial read.
- R7: While irqReq is high, vecAddr is 1 if the served source is enabled only in the shared-vector register. If its per-source bit is set, vecAddr is 2 for the pin, 3 for parallel write, 4 for parallel read, 5 for serial write and 6 for serial read. vecAddr is 0 while irqReq is low.
- R8: coreAccept high while irqReq is high clears the served source's pending flag and sets ackOut at that edge.
- R9: coreReturn high while ackOut is high clears ackOut at that edge. While ackOut is high, irqReq stays low and new enabled events stay pending.
- R10: An event on the served source in the same cycle as its acceptance stays pending afterwards.
- R11: A pending source whose enable bits have both been cleared raises no request until it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 shared-vector mask, 1 per-source enable |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr |
| serWrEvt | input | 1 | Serial write event pulse |
| serRdEvt | input | 1 | Serial read event pulse |
| parInStb | input | 1 | Parallel input strobe |
| parOutStb | input | 1 | Parallel output strobe |
| passiveMode | input | 1 | Parallel port is in passive mode |
| extIntPin | input | 1 | External interrupt pin |
| coreAccept | input | 1 | Core accepts the offered request |
| coreReturn | input | 1 | Core has finished the service routine |
| irqReq | output | 1 | Request offered to the core |
| vecAddr | output | 4 | Vector address of the offered request |
| ackOut | output | 1 | Acknowledge, high from accept until return |

## Verification
Two functions can meet in one clock edge: the acceptance of the served source, which clears its pending flag, and a new event on that same source, which sets it. The bench provokes this by pulsing serWrEvt in the accept cycle. It expects irqReq to come back with the serial-write vector after coreReturn. The same collision is also hit often by pseudo-random traffic. A behavioural reference model, advanced every clock edge, judges every output on every cycle.

// File: rtl/pivu_pkg.sv
package pivu_pkg;
  localparam int NUM_SRC = 5;

  // source index order equals service priority (0 is served first)
  localparam int SRC_EXT   = 0;
  localparam int SRC_PARWR = 1;
  localparam int SRC_PARRD = 2;
  localparam int SRC_SERWR = 3;
  localparam int SRC_SERRD = 4;

  typedef struct packed {
    logic grant;     // core accepts the offered request this cycle
    logic blockReq;  // service routine in progress, hold requests back
  } ctlStrobes_t;

  // bit position of a source's enable in the shared-vector register
  function automatic int legacyBitFor(input int idx, input int lsb);
    case (idx)
      SRC_EXT:   legacyBitFor = lsb;
      SRC_PARRD: legacyBitFor = lsb + 1;
      SRC_PARWR: legacyBitFor = lsb + 2;
      SRC_SERRD: legacyBitFor = lsb + 3;
      default:   legacyBitFor = lsb + 4;
    endcase
  endfunction
endpackage

// File: rtl/pivu_datapath.sv
module pivu_datapath
  import pivu_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int VEC_W        = 4,
  parameter int LEG_LSB      = 5,
  parameter int SHARED_VEC   = 1,
  parameter int EXT_VEC_BASE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              serWrEvt,
  input  logic              serRdEvt,
  input  logic              parInStb,
  input  logic              parOutStb,
  input  logic              passiveMode,
  input  logic              extIntPin,
  input  ctlStrobes_t       strobes,
  output logic              irqAvail,
  output logic              irqReq,
  output logic [VEC_W-1:0]  vecAddr
);
  localparam int N = NUM_SRC;
  localparam int LAST_VEC = EXT_VEC_BASE + N - 1;

  logic [N-1:0] legMask, extEn, pending, srcEvt, enabled, eligible, winner;
  logic         parInPrev, parOutPrev, extPrev;
  logic         unusedWrBits;

  assign unusedWrBits = ^regWrData;

  // edge detection of the strobes and the pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parInPrev  <= 1'b0;
      parOutPrev <= 1'b0;
      extPrev    <= 1'b0;
    end else begin
      parInPrev  <= parInStb;
      parOutPrev <= parOutStb;
      extPrev    <= extIntPin;
    end
  end

  always_comb begin
    srcEvt            = '0;
    srcEvt[SRC_EXT]   = extIntPin & ~extPrev;
    srcEvt[SRC_PARWR] = passiveMode & parInStb & ~parInPrev;
    srcEvt[SRC_PARRD] = passiveMode & parOutStb & ~parOutPrev;
    srcEvt[SRC_SERWR] = serWrEvt;
    srcEvt[SRC_SERRD] = serRdEvt;
  end

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      legMask <= '0;
      extEn   <= '0;
    end else if (regWe) begin
      if (!regAddr) begin
        for (int i = 0; i < N; i++) legMask[i] <= regWrData[legacyBitFor(i, LEG_LSB)];
      end else begin
        extEn <= regWrData[N-1:0];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      for (int i = 0; i < N; i++) regRdData[legacyBitFor(i, LEG_LSB)] = legMask[i];
    end else begin
      regRdData[N-1:0] = extEn;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : gSrc
      assign enabled[g]  = legMask[g] | extEn[g];
      assign eligible[g] = pending[g] & enabled[g];
    end
  endgenerate

  // fixed priority: lowest index wins
  always_comb begin
    logic found;
    found  = 1'b0;
    winner = '0;
    for (int i = 0; i < N; i++) begin
      if (eligible[i] && !found) begin
        winner[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign irqAvail = |eligible;
  assign irqReq   = irqAvail & ~strobes.blockReq;

  always_comb begin
    vecAddr = '0;
    if (irqReq) begin
      for (int i = 0; i < N; i++) begin
        if (winner[i]) vecAddr = extEn[i] ? VEC_W'(EXT_VEC_BASE + i) : VEC_W'(SHARED_VEC);
      end
    end
  end

  // a new event wins over the clear of an accepted request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~(winner & {N{strobes.grant}})) | (srcEvt & enabled);
  end

  AST_REQ_HELD_DURING_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blockReq |-> !irqReq); // R9
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (vecAddr >= VEC_W'(SHARED_VEC) && vecAddr <= VEC_W'(LAST_VEC))); // R7
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winner)); // R6
  AST_PARWR_NEEDS_PASSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending[SRC_PARWR]) |-> $past(passiveMode)); // R4
  AST_PARRD_NEEDS_PASSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending[SRC_PARRD]) |-> $past(passiveMode)); // R4
  AST_MASKED_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0 && enabled == '0) |=> pending == '0); // R3
endmodule

// File: rtl/pivu_control.sv
module pivu_control
  import pivu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqAvail,
  input  logic        coreAccept,
  input  logic        coreReturn,
  output ctlStrobes_t strobes,
  output logic        ackOut
);
  logic grantNow;

  assign grantNow         = coreAccept & irqAvail & ~ackOut;
  assign strobes.grant    = grantNow;
  assign strobes.blockReq = ackOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ackOut <= 1'b0;
    else if (grantNow)   ackOut <= 1'b1;
    else if (coreReturn) ackOut <= 1'b0;
  end

  AST_ACK_RISE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(coreAccept && irqAvail)); // R8
  AST_ACK_FALL_ON_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> $past(coreReturn)); // R9
endmodule

// File: rtl/perIrqVectorUnit.sv
module perIrqVectorUnit
  import pivu_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int VEC_W        = 4,
  parameter int LEG_LSB      = 5,
  parameter int SHARED_VEC   = 1,
  parameter int EXT_VEC_BASE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              serWrEvt,
  input  logic              serRdEvt,
  input  logic              parInStb,
  input  logic              parOutStb,
  input  logic              passiveMode,
  input  logic              extIntPin,
  input  logic              coreAccept,
  input  logic              coreReturn,
  output logic              irqReq,
  output logic [VEC_W-1:0]  vecAddr,
  output logic              ackOut
);
  ctlStrobes_t strobes;
  logic        irqAvail;

  pivu_datapath #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .LEG_LSB(LEG_LSB),
    .SHARED_VEC(SHARED_VEC), .EXT_VEC_BASE(EXT_VEC_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .serWrEvt(serWrEvt), .serRdEvt(serRdEvt), .parInStb(parInStb),
    .parOutStb(parOutStb), .passiveMode(passiveMode), .extIntPin(extIntPin),
    .strobes(strobes), .irqAvail(irqAvail), .irqReq(irqReq), .vecAddr(vecAddr)
  );

  pivu_control u_ctl (
    .clk(clk), .rstN(rstN), .irqAvail(irqAvail), .coreAccept(coreAccept),
    .coreReturn(coreReturn), .strobes(strobes), .ackOut(ackOut)
  );
endmodule

// File: tb/perIrqVectorUnit_tb.sv
module perIrqVectorUnit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regAddr = 1'b0;
  logic [15:0] regWrData = '0, regRdData;
  logic        serWrEvt = 0, serRdEvt = 0, parInStb = 0, parOutStb = 0;
  logic        passiveMode = 0, extIntPin = 0, coreAccept = 0, coreReturn = 0;
  logic        irqReq, ackOut;
  logic [3:0]  vecAddr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  perIrqVectorUnit u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .serWrEvt(serWrEvt),
    .serRdEvt(serRdEvt), .parInStb(parInStb), .parOutStb(parOutStb),
    .passiveMode(passiveMode), .extIntPin(extIntPin), .coreAccept(coreAccept),
    .coreReturn(coreReturn), .irqReq(irqReq), .vecAddr(vecAddr), .ackOut(ackOut)
  );

  // ---------------- reference model ----------------
  // index order: 0 pin, 1 par write, 2 par read, 3 ser write, 4 ser read
  int legBit[5] = '{5, 7, 6, 9, 8};
  bit mPend[5], mLeg[5], mExt[5];
  bit mAck, pIn, pOut, pExt;

  function automatic int modelWinner();
    for (int i = 0; i < 5; i++) if (mPend[i] && (mLeg[i] || mExt[i])) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 5; i++) begin mPend[i] = 0; mLeg[i] = 0; mExt[i] = 0; end
      mAck = 0; pIn = 0; pOut = 0; pExt = 0;
    end else begin
      bit ev[5];
      bit en[5];
      int w;
      bit grant;
      ev[0] = extIntPin && !pExt;
      ev[1] = passiveMode && parInStb && !pIn;
      ev[2] = passiveMode && parOutStb && !pOut;
      ev[3] = serWrEvt;
      ev[4] = serRdEvt;
      for (int i = 0; i < 5; i++) en[i] = mLeg[i] || mExt[i];
      w = modelWinner();
      grant = coreAccept && (w >= 0) && !mAck;
      for (int i = 0; i < 5; i++)
        mPend[i] = (mPend[i] && !(grant && i == w)) || (ev[i] && en[i]);
      if (grant) mAck = 1; else if (coreReturn) mAck = 0;
      if (regWe) begin
        for (int i = 0; i < 5; i++)
          if (!regAddr) mLeg[i] = regWrData[legBit[i]]; else mExt[i] = regWrData[i];
      end
      pIn = parInStb; pOut = parOutStb; pExt = extIntPin;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model
  task automatic compareAll();
    int w, eReq, eVec, eRd;
    w = modelWinner();
    eReq = (w >= 0 && !mAck) ? 1 : 0;
    eVec = eReq ? (mExt[w] ? 2 + w : 1) : 0;
    eRd = 0;
    for (int i = 0; i < 5; i++)
      if (!regAddr) eRd |= int'(mLeg[i]) << legBit[i]; else eRd |= int'(mExt[i]) << i;
    chk("R5/R6 irqReq", int'(irqReq), eReq);
    chk("R7 vecAddr", int'(vecAddr), eVec);
    chk("R8/R9 ackOut", int'(ackOut), int'(mAck));
    chk("R2 regRdData", int'(regRdData), eRd);
  endtask

  // one cycle: compare at the falling edge, then apply new stimulus
  task automatic cyc();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleIn();
    regWe = 0; serWrEvt = 0; serRdEvt = 0; coreAccept = 0; coreReturn = 0;
  endtask

  task automatic wrReg(input bit a, input logic [15:0] d);
    regWe = 1; regAddr = a; regWrData = d; cyc(); idleIn();
  endtask

  task automatic serviceOne(output int vec);
    vec = int'(vecAddr);
    coreAccept = 1; cyc(); idleIn();
    coreReturn = 1; cyc(); idleIn();
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk("R1 irqReq", int'(irqReq), 0);
    chk("R1 ackOut", int'(ackOut), 0);
    chk("R1 vecAddr", int'(vecAddr), 0);
    chk("R1 regRdData", int'(regRdData), 0);
    rstN = 1;
    cyc();

    // R3: nothing enabled, events ignored
    serWrEvt = 1; serRdEvt = 1; extIntPin = 1; cyc(); idleIn(); extIntPin = 0;
    cyc();
    chk("R3 masked irqReq", int'(irqReq), 0);

    // R2: register layout
    wrReg(0, 16'hFFFF);
    chk("R2 shared mask readback", int'(regRdData), 16'h03E0);
    regAddr = 1; wrReg(1, 16'h0000);
    chk("R2 per-source readback", int'(regRdData), 0);

    // R7 shared vector, R5 request timing
    serRdEvt = 1; cyc(); idleIn();
    chk("R5 request after event", int'(irqReq), 1);
    chk("R7 shared vector", int'(vecAddr), 1);
    serviceOne(v);
    chk("R8 cleared after service", int'(irqReq), 0);

    // R6 priority with per-source vectors
    wrReg(1, 16'h001F);
    passiveMode = 1;
    serWrEvt = 1; serRdEvt = 1; parInStb = 1; parOutStb = 1; extIntPin = 1;
    cyc(); idleIn();
    serviceOne(v); chk("R6 pin first", v, 2);
    serviceOne(v); chk("R6 par write second", v, 3);
    serviceOne(v); chk("R6 par read third", v, 4);
    serviceOne(v); chk("R6 ser write fourth", v, 5);
    serviceOne(v); chk("R6 ser read last", v, 6);
    parInStb = 0; parOutStb = 0; extIntPin = 0; cyc();

    // R4: parallel strobes ignored outside passive mode
    passiveMode = 0; parInStb = 1; cyc(); parInStb = 0; cyc();
    chk("R4 active-mode strobe ignored", int'(irqReq), 0);

    // R9: event during ack held; R10: same-source event at accept
    serWrEvt = 1; cyc(); idleIn();
    coreAccept = 1; serWrEvt = 1; cyc(); idleIn();
    chk("R9 request held during ack", int'(irqReq), 0);
    serRdEvt = 1; cyc(); idleIn();
    coreReturn = 1; cyc(); idleIn();
    chk("R10 re-event kept pending", int'(vecAddr), 5);
    serviceOne(v);
    chk("R9 held serial read served", int'(vecAddr), 6);
    serviceOne(v);

    // R11: enable dropped on a pending source
    serRdEvt = 1; cyc(); idleIn();
    wrReg(1, 16'h0000); wrReg(0, 16'h0000);
    chk("R11 disabled pending no request", int'(irqReq), 0);
    wrReg(0, 16'h0100);
    chk("R11 re-enabled request", int'(vecAddr), 1);
    serviceOne(v);

    // pseudo-random traffic, model compared each cycle
    for (int n = 0; n < 3000; n++) begin
      regWe = ($urandom_range(0, 15) == 0);
      regAddr = $urandom_range(0, 1);
      regWrData = 16'($urandom);
      serWrEvt = ($urandom_range(0, 7) == 0);
      serRdEvt = ($urandom_range(0, 7) == 0);
      parInStb = $urandom_range(0, 1);
      parOutStb = $urandom_range(0, 1);
      extIntPin = ($urandom_range(0, 3) == 0);
      passiveMode = ($urandom_range(0, 3) != 0);
      coreAccept = $urandom_range(0, 1);
      coreReturn = ($urandom_range(0, 2) == 0);
      cyc();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule